// File: doc/BRIEF.md
# Host DMA Abort and Pause Controller

This block sits between the schedule-walking DMA engines of a USB host controller and the system memory bus. Each read request from the engines goes through a valid/ready gate to the bus. The block keeps a count of the reads still waiting for a completion. A completion whose status reports an abort is treated as a fatal host error and is never retried. From the cycle of the abort, no further memory request is accepted and no new USB transaction is granted. A USB transaction already in flight may finish. After that the engines sit in a halted state until software cycles the run control. Sticky status flags record the error, a master abort and a target abort separately, and a system-error report. The interrupt follows the host-error flag when its enable is set.

Software can also pause the engines. While paused, no new memory request reaches the bus, but reads already accepted still return. Frame-start ticks keep passing through to the ports, so a pause costs no suspend/resume latency. Request back-pressure follows valid/ready rules. A request moves only in a cycle where `bus_req_valid` and `bus_req_ready` are both high, and the engine sees `eng_req_ready` only in that cycle. The gate may withdraw `bus_req_valid` without a transfer when a pause, an abort or a full read window arrives, so the bus must not assume the valid signal is held.

Top module: `hdma_abort_pause`

## Requirements
- R1: After reset, all four status flags, `irq`, `halted`, `paused`, `dma_busy`, `bus_req_valid` and `usb_grant` are 0.
- R2: In the running state with `ctl_pause` low, `bus_req_valid` equals `eng_req_valid`, `bus_req_addr` equals `eng_req_addr`, and `eng_req_ready` is `bus_req_valid & bus_req_ready`. Once `MAX_OUT` reads are outstanding, `bus_req_valid` is 0 until a completion returns.
- R3: A completion with `bus_cpl_status` not equal to 2'b00 is an abort. One cycle later `sts_host_err` is 1. Status 2'b01 (master abort) also sets `sts_mst_abort`, and 2'b10 (target abort) also sets `sts_tgt_abort`. Status 2'b11 sets neither of those two flags.
- R4: An abort sets `sts_sys_err` one cycle later if and only if `serr_en` is high in the abort cycle.
- R5: `irq` equals `sts_host_err & hse_irq_en` with no delay from the enable.
- R6: The flags are sticky. `sts_clr` bit 0/1/2/3 clears host-error/master-abort/target-abort/system-error one cycle later. If a flag is set and cleared in the same cycle, it stays set.
- R7: From the abort cycle on, no memory request is presented and no USB transaction is granted. `halted` rises one cycle after the in-flight USB transaction's `usb_done`, or one cycle after the abort if none is in flight.
- R8: While `ctl_run` stays high, `halted` stays 1. Dropping `ctl_run` clears it a cycle later. Raising `ctl_run` again resumes running one cycle after that.
- R9: While `ctl_pause` is high, `bus_req_valid` is 0 at once, and `paused` is 1 from the next cycle. Reads already accepted still complete, and `dma_busy` stays 1 until the last one returns.
- R10: After `ctl_pause` falls, the first request is presented on the next cycle.
- R11: `sof_out` follows `sof_tick` in the running and paused states and is 0 when idle, draining or halted.
- R12: An abort that arrives while paused ends in `halted`, and `paused` becomes 0.
- R13: `usb_grant` equals `usb_go` only while running with no USB transaction in flight. A transaction is in flight from its grant until `usb_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_run | input | 1 | Software run control |
| ctl_pause | input | 1 | Software pause control |
| hse_irq_en | input | 1 | Interrupt enable for host error |
| serr_en | input | 1 | System-error report enable |
| sts_clr | input | 4 | Write-one-to-clear pulses, bit 0 host err, 1 master abort, 2 target abort, 3 system err |
| eng_req_valid | input | 1 | Engine read request valid |
| eng_req_ready | output | 1 | Engine read request accepted |
| eng_req_addr | input | AW | Engine read address |
| bus_req_valid | output | 1 | Bus read request valid |
| bus_req_ready | input | 1 | Bus accepts request |
| bus_req_addr | output | AW | Bus read address |
| bus_cpl_valid | input | 1 | Read completion strobe |
| bus_cpl_status | input | 2 | 00 ok, 01 master abort, 10 target abort, 11 other abort |
| usb_go | input | 1 | Engine asks to start a USB transaction |
| usb_grant | output | 1 | Transaction start permitted |
| usb_done | input | 1 | In-flight USB transaction finished |
| sof_tick | input | 1 | Frame-start tick from the frame timer |
| sof_out | output | 1 | Frame-start tick to the ports |
| sts_host_err | output | 1 | Sticky host error |
| sts_mst_abort | output | 1 | Sticky master abort seen |
| sts_tgt_abort | output | 1 | Sticky target abort seen |
| sts_sys_err | output | 1 | Sticky system error signalled |
| irq | output | 1 | Interrupt |
| halted | output | 1 | Engines halted after error |
| paused | output | 1 | Engines paused |
| dma_busy | output | 1 | Reads outstanding |

## Verification
The gates on `bus_req_valid`, `eng_req_ready`, `usb_grant`, `sof_out` and `irq` are combinational. The bench checks them one time step after it drives inputs on the falling edge, within the same cycle. Flags, `halted`, `paused` and `dma_busy` are registered once, so they change at the rising edge after the stimulus, and the bench samples them at the following falling edge. The exits from pause and halt each take one state update. A drop of `ctl_pause` is therefore checked for silence in its own cycle and for a presented request in the next one.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_PAUSE = 3'd2,
    ST_DRAIN = 3'd3,
    ST_HALT  = 3'd4
  } ctl_state_e;

  localparam int unsigned NFLAG    = 4;
  localparam int unsigned FL_HOST  = 0;
  localparam int unsigned FL_MABT  = 1;
  localparam int unsigned FL_TABT  = 2;
  localparam int unsigned FL_SERR  = 3;

  localparam logic [1:0] CPL_OK   = 2'b00;
  localparam logic [1:0] CPL_MABT = 2'b01;
  localparam logic [1:0] CPL_TABT = 2'b10;
endpackage

// File: rtl/hdma_rd_tracker.sv
module hdma_rd_tracker #(
  parameter int unsigned MAX_OUT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic retire,
  output logic full,
  output logic busy
);
  localparam int unsigned CW = $clog2(MAX_OUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_OUT);

  logic [CW-1:0] cnt_q;
  logic          dec;

  assign dec = retire && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (issue && !dec) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec && !issue) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign full = (cnt_q == LIMIT);
  assign busy = (cnt_q != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LIMIT) |-> !(issue && !retire)) else $error("read window overflow"); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (cnt_q != '0)) else $error("completion without outstanding read"); // R9
endmodule

// File: rtl/hdma_err_flags.sv
module hdma_err_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        f_q <= 1'b0;
      end else if (set[i]) begin
        f_q <= 1'b1;
      end else if (clr[i]) begin
        f_q <= 1'b0;
      end
    end
    assign flags[i] = f_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]) else $error("flag lost"); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]) else $error("set not seen"); // R6
  end
endmodule

// File: rtl/hdma_ctrl_fsm.sv
module hdma_ctrl_fsm
  import hdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       pause,
  input  logic       abort,
  input  logic       usb_go,
  input  logic       usb_done,
  output ctl_state_e state,
  output logic       mem_allow,
  output logic       usb_grant
);
  ctl_state_e st_q, st_d;
  logic       usb_busy_q;
  logic       err_path;

  assign err_path = abort && (st_q != ST_DRAIN) && (st_q != ST_HALT);

  always_comb begin
    st_d = st_q;
    if (err_path) begin
      st_d = (usb_busy_q && !usb_done) ? ST_DRAIN : ST_HALT;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (run) st_d = pause ? ST_PAUSE : ST_RUN;
        ST_RUN:   if (!run) st_d = ST_IDLE; else if (pause) st_d = ST_PAUSE;
        ST_PAUSE: if (!run) st_d = ST_IDLE; else if (!pause) st_d = ST_RUN;
        ST_DRAIN: if (usb_done || !usb_busy_q) st_d = ST_HALT;
        ST_HALT:  if (!run) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  assign mem_allow = (st_q == ST_RUN) && !pause && !abort;
  assign usb_grant = usb_go && (st_q == ST_RUN) && !usb_busy_q && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      usb_busy_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (usb_grant) begin
        usb_busy_q <= 1'b1;
      end else if (usb_done) begin
        usb_busy_q <= 1'b0;
      end
    end
  end

  assign state = st_q;

  AST_NO_GRANT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DRAIN) || (st_q == ST_HALT)) |-> !usb_grant) else $error("grant after abort"); // R7
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    err_path |=> ((st_q == ST_DRAIN) || (st_q == ST_HALT))) else $error("abort ignored"); // R12
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_HALT) && run) |=> (st_q == ST_HALT)) else $error("halt left while running"); // R8
  AST_ONE_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_busy_q && !usb_done) |-> !usb_grant) else $error("second transaction granted"); // R13
endmodule

// File: rtl/hdma_abort_pause.sv
module hdma_abort_pause
  import hdma_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned MAX_OUT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_run,
  input  logic          ctl_pause,
  input  logic          hse_irq_en,
  input  logic          serr_en,
  input  logic [3:0]    sts_clr,
  input  logic          eng_req_valid,
  output logic          eng_req_ready,
  input  logic [AW-1:0] eng_req_addr,
  output logic          bus_req_valid,
  input  logic          bus_req_ready,
  output logic [AW-1:0] bus_req_addr,
  input  logic          bus_cpl_valid,
  input  logic [1:0]    bus_cpl_status,
  input  logic          usb_go,
  output logic          usb_grant,
  input  logic          usb_done,
  input  logic          sof_tick,
  output logic          sof_out,
  output logic          sts_host_err,
  output logic          sts_mst_abort,
  output logic          sts_tgt_abort,
  output logic          sts_sys_err,
  output logic          irq,
  output logic          halted,
  output logic          paused,
  output logic          dma_busy
);
  ctl_state_e       state;
  logic             mem_allow;
  logic             win_full;
  logic             abort;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flags;

  assign abort = bus_cpl_valid && (bus_cpl_status != CPL_OK);

  hdma_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctl_run),
    .pause     (ctl_pause),
    .abort     (abort),
    .usb_go    (usb_go),
    .usb_done  (usb_done),
    .state     (state),
    .mem_allow (mem_allow),
    .usb_grant (usb_grant)
  );

  assign bus_req_valid = eng_req_valid && mem_allow && !win_full;
  assign bus_req_addr  = eng_req_addr;
  assign eng_req_ready = bus_req_valid && bus_req_ready;

  hdma_rd_tracker #(.MAX_OUT(MAX_OUT)) u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (eng_req_ready),
    .retire (bus_cpl_valid),
    .full   (win_full),
    .busy   (dma_busy)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FL_HOST] = abort;
    flag_set[FL_MABT] = bus_cpl_valid && (bus_cpl_status == CPL_MABT);
    flag_set[FL_TABT] = bus_cpl_valid && (bus_cpl_status == CPL_TABT);
    flag_set[FL_SERR] = abort && serr_en;
  end

  hdma_err_flags #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (sts_clr),
    .flags (flags)
  );

  assign sts_host_err  = flags[FL_HOST];
  assign sts_mst_abort = flags[FL_MABT];
  assign sts_tgt_abort = flags[FL_TABT];
  assign sts_sys_err   = flags[FL_SERR];
  assign irq           = sts_host_err && hse_irq_en;

  assign halted  = (state == ST_HALT);
  assign paused  = (state == ST_PAUSE);
  assign sof_out = sof_tick && ((state == ST_RUN) || (state == ST_PAUSE));

  AST_PAUSE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_pause |-> !bus_req_valid) else $error("request while paused"); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !bus_req_valid) else $error("request while halted"); // R7
  AST_HSE_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> sts_host_err) else $error("host error not latched"); // R3
  AST_SSE_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && serr_en) |=> sts_sys_err) else $error("system error not latched"); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> hse_irq_en) else $error("interrupt without enable"); // R5
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req_ready |-> (eng_req_valid && bus_req_ready)) else $error("spurious ready"); // R2
endmodule

// File: tb/hdma_abort_pause_tb.sv
`timescale 1ns/1ps
module hdma_abort_pause_tb_top;
  localparam int AW = 32;
  localparam int MAX_OUT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_run, ctl_pause, hse_irq_en, serr_en;
  logic [3:0] sts_clr;
  logic eng_req_valid, eng_req_ready;
  logic [AW-1:0] eng_req_addr, bus_req_addr;
  logic bus_req_valid, bus_req_ready;
  logic bus_cpl_valid;
  logic [1:0] bus_cpl_status;
  logic usb_go, usb_grant, usb_done;
  logic sof_tick, sof_out;
  logic sts_host_err, sts_mst_abort, sts_tgt_abort, sts_sys_err;
  logic irq, halted, paused, dma_busy;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  hdma_abort_pause #(.AW(AW), .MAX_OUT(MAX_OUT)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_run(ctl_run), .ctl_pause(ctl_pause),
    .hse_irq_en(hse_irq_en), .serr_en(serr_en), .sts_clr(sts_clr),
    .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready), .eng_req_addr(eng_req_addr),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready), .bus_req_addr(bus_req_addr),
    .bus_cpl_valid(bus_cpl_valid), .bus_cpl_status(bus_cpl_status),
    .usb_go(usb_go), .usb_grant(usb_grant), .usb_done(usb_done),
    .sof_tick(sof_tick), .sof_out(sof_out),
    .sts_host_err(sts_host_err), .sts_mst_abort(sts_mst_abort),
    .sts_tgt_abort(sts_tgt_abort), .sts_sys_err(sts_sys_err),
    .irq(irq), .halted(halted), .paused(paused), .dma_busy(dma_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ctl_run = 0; ctl_pause = 0; hse_irq_en = 0; serr_en = 0;
    sts_clr = '0; eng_req_valid = 0; eng_req_addr = '0; bus_req_ready = 1;
    bus_cpl_valid = 0; bus_cpl_status = 2'b00; usb_go = 0; usb_done = 0; sof_tick = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 flags", {28'd0, sts_host_err, sts_mst_abort, sts_tgt_abort, sts_sys_err}, 32'd0);
    chk("R1 irq/halted/paused/busy", {28'd0, irq, halted, paused, dma_busy}, 32'd0);
    chk("R1 bus_req_valid", bus_req_valid, 0);
    chk("R1 usb_grant", usb_grant, 0);
  endtask

  task automatic t_forward();
    ctl_run = 1;
    tick();
    eng_req_valid = 1; eng_req_addr = 32'h1000_0040;
    settle();
    chk("R2 valid passes", bus_req_valid, 1);
    chk("R2 addr passes", bus_req_addr, 32'h1000_0040);
    chk("R2 ready follows bus", eng_req_ready, 1);
    bus_req_ready = 0;
    settle();
    chk("R2 back-pressure holds ready low", eng_req_ready, 0);
    bus_req_ready = 1;
    for (int i = 0; i < MAX_OUT; i++) tick();
    settle();
    chk("R2 window full blocks", bus_req_valid, 0);
    chk("R9 busy with reads out", dma_busy, 1);
    eng_req_valid = 0;
    bus_cpl_valid = 1; bus_cpl_status = 2'b00;
    for (int i = 0; i < MAX_OUT; i++) tick();
    bus_cpl_valid = 0;
    settle();
    chk("R9 busy clears after returns", dma_busy, 0);
    chk("R3 ok completion sets nothing", sts_host_err, 0);
  endtask

  task automatic t_pause();
    eng_req_valid = 1;
    tick();
    ctl_pause = 1;
    settle();
    chk("R9 pause blocks at once", bus_req_valid, 0);
    tick();
    chk("R9 paused state", paused, 1);
    chk("R9 busy during pause", dma_busy, 1);
    sof_tick = 1;
    settle();
    chk("R11 sof runs while paused", sof_out, 1);
    sof_tick = 0;
    bus_cpl_valid = 1; bus_cpl_status = 2'b00;
    tick();
    bus_cpl_valid = 0;
    chk("R9 accepted read completes", dma_busy, 0);
    ctl_pause = 0;
    settle();
    chk("R10 no request in release cycle", bus_req_valid, 0);
    tick();
    chk("R10 request next cycle", bus_req_valid, 1);
    eng_req_valid = 0;
  endtask

  task automatic t_abort_master();
    hse_irq_en = 1; serr_en = 0;
    usb_go = 1;
    settle();
    chk("R13 grant while running", usb_grant, 1);
    tick();
    settle();
    chk("R13 no second grant in flight", usb_grant, 0);
    usb_go = 0;
    eng_req_valid = 1;
    tick();
    bus_cpl_valid = 1; bus_cpl_status = 2'b01;
    settle();
    chk("R7 no request in abort cycle", bus_req_valid, 0);
    tick();
    bus_cpl_valid = 0; bus_cpl_status = 2'b00;
    chk("R3 host err", sts_host_err, 1);
    chk("R3 master abort flag", sts_mst_abort, 1);
    chk("R3 target abort clear", sts_tgt_abort, 0);
    chk("R4 sys err needs enable", sts_sys_err, 0);
    chk("R5 irq", irq, 1);
    chk("R7 draining not halted", halted, 0);
    usb_go = 1;
    settle();
    chk("R7 no grant while draining", usb_grant, 0);
    usb_go = 0;
    tick();
    chk("R7 still draining", halted, 0);
    usb_done = 1;
    tick();
    usb_done = 0;
    chk("R7 halted after done", halted, 1);
    chk("R7 no request halted", bus_req_valid, 0);
    tick();
    chk("R8 halt held while run high", halted, 1);
    ctl_run = 0;
    tick();
    chk("R8 halt left on run low", halted, 0);
    ctl_run = 1;
    tick();
    settle();
    chk("R8 running again", bus_req_valid, 1);
    eng_req_valid = 0;
    sts_clr = 4'b1111;
    tick();
    sts_clr = 4'b0000;
    chk("R6 clear all", {28'd0, sts_host_err, sts_mst_abort, sts_tgt_abort, sts_sys_err}, 32'd0);
    chk("R5 irq drops with status", irq, 0);
  endtask

  task automatic t_abort_target_paused();
    hse_irq_en = 0; serr_en = 1;
    eng_req_valid = 1;
    tick();
    eng_req_valid = 0;
    ctl_pause = 1;
    tick();
    chk("R12 paused before abort", paused, 1);
    bus_cpl_valid = 1; bus_cpl_status = 2'b10; sts_clr = 4'b0001;
    tick();
    bus_cpl_valid = 0; bus_cpl_status = 2'b00; sts_clr = 4'b0000;
    chk("R6 set beats clear", sts_host_err, 1);
    chk("R3 target abort flag", sts_tgt_abort, 1);
    chk("R3 master abort clear", sts_mst_abort, 0);
    chk("R4 sys err with enable", sts_sys_err, 1);
    chk("R5 irq masked", irq, 0);
    chk("R12 halted not paused", {30'd0, halted, paused}, 32'd2);
    sof_tick = 1;
    settle();
    chk("R11 sof off when halted", sof_out, 0);
    sof_tick = 0;
    hse_irq_en = 1;
    settle();
    chk("R5 irq follows enable", irq, 1);
    sts_clr = 4'b0001;
    tick();
    sts_clr = 4'b0000;
    chk("R6 single clear", sts_host_err, 0);
    chk("R6 other flag kept", sts_tgt_abort, 1);
    ctl_pause = 0; ctl_run = 0;
    tick();
    sts_clr = 4'b1111;
    tick();
    sts_clr = 4'b0000;
    sof_tick = 1;
    settle();
    chk("R11 sof off when idle", sof_out, 0);
    sof_tick = 0;
  endtask

  task automatic t_abort_other();
    ctl_run = 1;
    tick();
    eng_req_valid = 1;
    tick();
    eng_req_valid = 0;
    bus_cpl_valid = 1; bus_cpl_status = 2'b11;
    tick();
    bus_cpl_valid = 0; bus_cpl_status = 2'b00;
    chk("R3 other abort host err", sts_host_err, 1);
    chk("R3 other abort no ma/ta", {30'd0, sts_mst_abort, sts_tgt_abort}, 32'd0);
    chk("R7 halted at once without txn", halted, 1);
  endtask

  initial begin
    t_reset();
    t_forward();
    t_pause();
    t_abort_master();
    t_abort_target_paused();
    t_abort_other();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule